// File: doc/BRIEF.md
# Zero-Offset Dither Calibration Controller

This block prepares a digitally modulated power loop for a deliberate limit-cycle measurement. In normal operation it passes the digital voltage reference through to the loop, delayed by one register. When a test is requested, it latches the current high-resolution duty command as the steady-state duty value. No filtering is applied to this value. At the same time it tells the modulator to switch to coarse resolution.

Coarse resolution drops the low bits of the command. From those bits the block computes a signed reference correction that moves the average command to the exact midpoint between two adjacent coarse duty levels. This gives a symmetric oscillation with no dc bias. The corrected reference is held for the whole test. When the done handshake arrives, the saved original reference is written back and fine resolution returns on the same cycle.

Top module: `zero_offset_cal`

## Requirements
- R1: While reset is held and just after it is released, `refOut`, `dutySteady` and `coarseSel` are all zero.
- R2: When no test is running and `testStart` is low, `refOut` equals the `refIn` value sampled at the previous clock edge, and `coarseSel` stays 0.
- R3: When no test is running, a high `testStart` at a clock edge starts a test. After that edge `coarseSel` is 1 and `dutySteady` holds the `dutyCmd` sampled at that edge.
- R4: With the default widths (10-bit command, 7-bit coarse modulator, 12-bit reference), the low 3 bits `k = dutyCmd[2:0]` are the dropped bits. At the start edge `refOut` becomes `(refIn + 4 - k) mod 4096`, where 4 (binary 100) is the coarse midpoint. For example, k = 001 adds 3, and k = 111 subtracts 3.
- R5: During a test, `refOut` and `dutySteady` do not change, whatever `refIn` and `dutyCmd` do.
- R6: A `testStart` that arrives during a test is ignored: `coarseSel` stays 1 and the outputs keep their values.
- R7: A high `testDone` during a test ends it. After that edge `refOut` equals the `refIn` sampled at the start edge and `coarseSel` is 0. Reference tracking resumes on the next cycle.
- R8: A `testDone` while no test is running has no effect: `coarseSel` stays 0 and `refOut` keeps tracking `refIn`.
- R9: When `testStart` and `testDone` are both high while no test is running, the start is taken and the done is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dutyCmd | input | FINE_W | High-resolution duty command from the compensator |
| refIn | input | REF_W | Digital voltage reference from the system |
| testStart | input | 1 | Request to begin the limit-cycle test |
| testDone | input | 1 | Signals that parameter adjustment is complete |
| refOut | output | REF_W | Reference delivered to the loop (tracked or corrected) |
| dutySteady | output | FINE_W | Duty command captured at test start |
| coarseSel | output | 1 | 1 selects coarse modulator resolution |

## Verification
The bench uses the default widths: a 10-bit command, a 7-bit coarse level and a 12-bit reference. With these widths there are only eight dropped-bit codes, so every code is exercised. Each code is run against references at zero, at one, at mid-scale and at the top of the range, where the correction wraps modulo 4096. For each case the expected correction is computed arithmetically. The bench also checks that the captured duty and the corrected reference stay frozen against changing inputs and repeated start requests. It checks the restore of the original reference, and the combined start-and-done case.

// File: rtl/zodc_pkg.sv
package zodc_pkg;
  // strobes from control to datapath; at most one is high per cycle
  typedef struct packed {
    logic track;    // follow the incoming reference
    logic capture;  // latch duty, save reference, apply correction
    logic restore;  // write the saved reference back
  } dpCtl_t;

  typedef enum logic {S_IDLE = 1'b0, S_DITHER = 1'b1} calState_t;
endpackage

// File: rtl/zodc_ctrl.sv
module zodc_ctrl
  import zodc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   testStart,
  input  logic   testDone,
  output dpCtl_t ctl,
  output logic   coarseSel
);
  calState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      S_IDLE: begin
        if (testStart) begin
          nextState   = S_DITHER;
          ctl.capture = 1'b1;
        end else begin
          ctl.track = 1'b1;
        end
      end
      S_DITHER: begin
        if (testDone) begin
          nextState   = S_IDLE;
          ctl.restore = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign coarseSel = (state == S_DITHER);

  // start from idle enters the test, even with done also high
  p_enter_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!coarseSel && testStart) |=> coarseSel);
  // repeated start inside the test does not disturb it
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (coarseSel && !testDone) |=> coarseSel);
  p_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (coarseSel && testDone) |=> !coarseSel);
  p_idle_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!coarseSel && !testStart) |=> !coarseSel);
endmodule

// File: rtl/zodc_datapath.sv
module zodc_datapath
  import zodc_pkg::*;
#(
  parameter int FINE_W   = 10,
  parameter int COARSE_W = 7,
  parameter int REF_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [FINE_W-1:0] dutyCmd,
  input  logic [REF_W-1:0]  refIn,
  output logic [REF_W-1:0]  refOut,
  output logic [FINE_W-1:0] dutySteady
);
  localparam int DROP_W = FINE_W - COARSE_W;
  localparam int CORR_W = DROP_W + 1;
  localparam logic [DROP_W-1:0] MID_CODE = DROP_W'(1) << (DROP_W - 1);

  logic [DROP_W-1:0] lowBits;
  logic [CORR_W-1:0] corr;      // two's complement, MID - lowBits
  logic [REF_W-1:0]  corrExt;
  logic [REF_W-1:0]  savedRef;

  assign lowBits = dutyCmd[DROP_W-1:0];
  assign corr    = {1'b0, MID_CODE} - {1'b0, lowBits};

  generate
    if (REF_W > CORR_W) begin : g_sext
      assign corrExt = {{(REF_W-CORR_W){corr[CORR_W-1]}}, corr};
    end else begin : g_trunc
      assign corrExt = corr[REF_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refOut     <= '0;
      savedRef   <= '0;
      dutySteady <= '0;
    end else begin
      if (ctl.track) refOut <= refIn;
      if (ctl.capture) begin
        savedRef   <= refIn;
        dutySteady <= dutyCmd;
        refOut     <= refIn + corrExt;
      end
      if (ctl.restore) refOut <= savedRef;
    end
  end

  // saved reference only moves on a capture strobe
  p_saved_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(savedRef));
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.track, ctl.capture, ctl.restore}));
endmodule

// File: rtl/zero_offset_cal.sv
module zero_offset_cal #(
  parameter int FINE_W   = 10,
  parameter int COARSE_W = 7,
  parameter int REF_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FINE_W-1:0] dutyCmd,
  input  logic [REF_W-1:0]  refIn,
  input  logic              testStart,
  input  logic              testDone,
  output logic [REF_W-1:0]  refOut,
  output logic [FINE_W-1:0] dutySteady,
  output logic              coarseSel
);
  zodc_pkg::dpCtl_t ctl;

  zodc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .testStart (testStart),
    .testDone  (testDone),
    .ctl       (ctl),
    .coarseSel (coarseSel)
  );

  zodc_datapath #(.FINE_W(FINE_W), .COARSE_W(COARSE_W), .REF_W(REF_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dutyCmd    (dutyCmd),
    .refIn      (refIn),
    .refOut     (refOut),
    .dutySteady (dutySteady)
  );

  p_track_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!coarseSel && !testStart) |=> (refOut == $past(refIn)));
  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!coarseSel && testStart) |=> (dutySteady == $past(dutyCmd)));
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (coarseSel && !testDone) |=> ($stable(refOut) && $stable(dutySteady)));
endmodule

// File: tb/zero_offset_cal_tb.sv
module zero_offset_cal_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  dutyCmd = '0;
  logic [11:0] refIn = '0;
  logic        testStart = 1'b0;
  logic        testDone = 1'b0;
  logic [11:0] refOut;
  logic [9:0]  dutySteady;
  logic        coarseSel;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  zero_offset_cal u_dut (
    .clk(clk), .rstN(rstN), .dutyCmd(dutyCmd), .refIn(refIn),
    .testStart(testStart), .testDone(testDone),
    .refOut(refOut), .dutySteady(dutySteady), .coarseSel(coarseSel)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] refs [6];
    logic [11:0] expRef;
    logic [9:0]  duty;
    refs[0] = 12'h000; refs[1] = 12'h001; refs[2] = 12'h7FF;
    refs[3] = 12'hFFE; refs[4] = 12'hFFF; refs[5] = 12'h123;

    step(); step();
    chk(refOut == 0, "R1 refOut", int'(refOut), 0);
    chk(dutySteady == 0, "R1 dutySteady", int'(dutySteady), 0);
    chk(coarseSel == 0, "R1 coarseSel", int'(coarseSel), 0);
    rstN = 1'b1;
    step();
    chk(refOut == 0 && coarseSel == 0, "R1 after release", int'(refOut), 0);

    for (int ri = 0; ri < 6; ri++) begin
      for (int k = 0; k < 8; k++) begin
        duty   = {7'(ri * 19 + k * 5), 3'(k)};
        refIn  = refs[ri];
        dutyCmd = duty;
        step();
        chk(refOut == refs[ri], "R2 tracking", int'(refOut), int'(refs[ri]));
        chk(coarseSel == 0, "R2 fine select", int'(coarseSel), 0);

        testStart = 1'b1;
        step();
        testStart = 1'b0;
        expRef = 12'(int'(refs[ri]) + 4 - k);
        chk(coarseSel == 1, "R3 coarse select", int'(coarseSel), 1);
        chk(dutySteady == duty, "R3 captured duty", int'(dutySteady), int'(duty));
        chk(refOut == expRef, "R4 corrected ref", int'(refOut), int'(expRef));

        refIn   = refs[ri] ^ 12'h5A5;
        dutyCmd = ~duty;
        step();
        testStart = 1'b1;
        step();
        testStart = 1'b0;
        step();
        chk(refOut == expRef, "R5 ref frozen", int'(refOut), int'(expRef));
        chk(dutySteady == duty, "R5 duty frozen", int'(dutySteady), int'(duty));
        chk(coarseSel == 1, "R6 start ignored", int'(coarseSel), 1);

        testDone = 1'b1;
        step();
        testDone = 1'b0;
        chk(refOut == refs[ri], "R7 restored ref", int'(refOut), int'(refs[ri]));
        chk(coarseSel == 0, "R7 fine select", int'(coarseSel), 0);
        step();
        chk(refOut == (refs[ri] ^ 12'h5A5), "R7 tracking resumes", int'(refOut),
            int'(refs[ri] ^ 12'h5A5));
      end
    end

    // done while idle
    refIn = 12'h2C4;
    testDone = 1'b1;
    step();
    testDone = 1'b0;
    chk(coarseSel == 0, "R8 idle done select", int'(coarseSel), 0);
    chk(refOut == 12'h2C4, "R8 idle done tracking", int'(refOut), 12'h2C4);

    // start and done together from idle; low bits 110 -> correction -2
    refIn = 12'h400;
    dutyCmd = 10'h2A6;
    testStart = 1'b1;
    testDone = 1'b1;
    step();
    testStart = 1'b0;
    testDone = 1'b0;
    chk(coarseSel == 1, "R9 start wins", int'(coarseSel), 1);
    chk(refOut == 12'h3FE, "R9 corrected ref", int'(refOut), 12'h3FE);
    testDone = 1'b1;
    step();
    testDone = 1'b0;
    chk(refOut == 12'h400 && coarseSel == 0, "R9 restore", int'(refOut), 12'h400);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule